// File: doc/BRIEF.md
# Ping-Pong Block Reverser

This block sits on the feedback path between a forward sample delay chain and a reverse delay chain. In reversal mode it reverses the order of samples block by block. Two stacks take turns. One stack takes in every sample that leaves the forward path. The other stack is emptied, newest entry first, into the reverse path. A high-to-low transition on the transfer input swaps the two roles. The length of each reversed block is therefore set by the distance between transfer pulses.

In pass-through mode the stacks are left untouched. A single register then carries the forward sample to the reverse path, one cycle late. A hold input freezes the whole block: no sample is taken, no stack moves, and the transfer input is not sampled. The block does no filter arithmetic.

Top module: `pingpong_reverser`

## Requirements
- R1: After reset, `rev_data_o` is 0, `wr_sel_o` is 0 (stack 0 is the one written), `ovf_o` is 0, and both stacks are empty.
- R2: In reversal mode (`bypass_i` = 0), every cycle with `hold_i` = 0 does three things. It pushes `fwd_data_i` onto the stack that `wr_sel_o` selects. It pops the other stack. It shows the popped value on `rev_data_o` after that clock edge. A stack is never pushed and popped in the same cycle.
- R3: `xfer_i` is sampled on each cycle with `hold_i` = 0. The roles swap (`wr_sel_o` toggles after the edge) only when the previous sample was 1 and the present one is 0, and only in reversal mode. Keeping `xfer_i` at 0 causes no further swaps.
- R4: The sample pushed in the cycle of a falling edge is the last one of its block. The N samples of a block come out in reverse order over the N advancing cycles that follow the swap.
- R5: With `bypass_i` = 1 and `hold_i` = 0, `rev_data_o` equals the `fwd_data_i` of the previous cycle. Falling edges of `xfer_i` cause no swap.
- R6: While `hold_i` = 1, `rev_data_o`, `wr_sel_o`, `ovf_o` and both stacks keep their values, and `xfer_i` is not sampled.
- R7: Each stack holds 16 entries. A push onto a full stack is dropped, and `ovf_o` is 1 in the cycle after the dropped push. The 16 entries already stored are unchanged.
- R8: A pop from an empty stack yields 0 on `rev_data_o`.
- R9: Pass-through mode leaves stack contents and roles unchanged. After a return to reversal mode, draining resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | 1 freezes all state and sampling |
| bypass_i | input | 1 | 0 = reversal through the stacks, 1 = single-register pass-through |
| xfer_i | input | 1 | Transfer control; a high-to-low transition swaps the stack roles |
| fwd_data_i | input | 10 | Sample leaving the forward delay chain |
| rev_data_o | output | 10 | Sample sent to the reverse delay chain |
| wr_sel_o | output | 1 | Index of the stack now being written |
| ovf_o | output | 1 | A push was dropped on a full stack in the previous advancing cycle |

## Verification
The in-line assertions run on every cycle and check four things. Roles change only after a cycle that advanced in reversal mode with the transfer input low. A held cycle leaves the output and the role unchanged. Pass-through output tracks the previous input. The stacks stay within their depth, and a push onto a full stack leaves it unchanged and raises the overflow flag.

Some properties depend on history over many cycles, and only the bench's scenarios can show them. These are the actual reversed order of a block, the absence of a repeated swap while the transfer input stays low, the zero returned by an empty stack, the survival of stack contents across pass-through and hold, and the return to a cleared state after a mid-run reset.

// File: rtl/pprev_pkg.sv
package pprev_pkg;

    localparam int unsigned DATA_W     = 10;
    localparam int unsigned LIFO_DEPTH = 16;
    localparam int unsigned NUM_LIFO   = 2;

    typedef enum logic {
        PATH_REVERSE = 1'b0,
        PATH_BYPASS  = 1'b1
    } path_mode_e;

endpackage

// File: rtl/pprev_lifo.sv
module pprev_lifo #(
    parameter int unsigned W     = pprev_pkg::DATA_W,
    parameter int unsigned DEPTH = pprev_pkg::LIFO_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output logic         full_o,
    output logic         drop_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } lifo_st_t;

    lifo_st_t s_d, s_q;
    logic     full_c;
    logic     empty_c;

    always_comb begin
        s_d     = s_q;
        full_c  = (s_q.cnt == CW'(DEPTH));
        empty_c = (s_q.cnt == '0);
        dout_o  = '0;
        if (pop_i && !empty_c) begin
            dout_o = s_q.mem[AW'(s_q.cnt - CW'(1))];
            s_d.cnt = s_q.cnt - CW'(1);
        end else if (push_i && !full_c) begin
            s_d.mem[AW'(s_q.cnt)] = din_i;
            s_d.cnt = s_q.cnt + CW'(1);
        end
        full_o = full_c;
        drop_o = push_i && full_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R7
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && s_q.cnt == CW'(DEPTH)) |=> (s_q.cnt == CW'(DEPTH)));

endmodule

// File: rtl/pprev_fall_det.sv
module pprev_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en_i,
    input  logic lvl_i,
    output logic fall_o
);
    typedef struct packed {
        logic lvl;
    } det_st_t;

    det_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        fall_o = 1'b0;
        if (sample_en_i) begin
            s_d.lvl = lvl_i;
            fall_o  = s_q.lvl && !lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    no_sample_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en_i |-> !fall_o);

endmodule

// File: rtl/pingpong_reverser.sv
module pingpong_reverser #(
    parameter int unsigned W     = pprev_pkg::DATA_W,
    parameter int unsigned DEPTH = pprev_pkg::LIFO_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_i,
    input  logic         bypass_i,
    input  logic         xfer_i,
    input  logic [W-1:0] fwd_data_i,
    output logic [W-1:0] rev_data_o,
    output logic         wr_sel_o,
    output logic         ovf_o
);
    import pprev_pkg::*;

    localparam int unsigned NL = NUM_LIFO;

    typedef struct packed {
        logic [W-1:0] rev_data;
        logic         wr_sel;
        logic         ovf;
    } top_st_t;

    top_st_t s_d, s_q;

    logic                 advance;
    logic                 rev_mode;
    logic                 fall;
    logic [NL-1:0]        push_v;
    logic [NL-1:0]        pop_v;
    logic [NL-1:0]        full_v;
    logic [NL-1:0]        drop_v;
    logic [NL-1:0][W-1:0] pop_data_v;

    assign advance  = !hold_i;
    assign rev_mode = advance && (bypass_i == PATH_REVERSE);

    pprev_fall_det u_fall (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en_i (advance),
        .lvl_i       (xfer_i),
        .fall_o      (fall)
    );

    for (genvar g = 0; g < NL; g++) begin : g_lifo
        assign push_v[g] = rev_mode && (s_q.wr_sel == 1'(g));
        assign pop_v[g]  = rev_mode && (s_q.wr_sel != 1'(g));

        pprev_lifo #(.W(W), .DEPTH(DEPTH)) u_lifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .push_i (push_v[g]),
            .pop_i  (pop_v[g]),
            .din_i  (fwd_data_i),
            .dout_o (pop_data_v[g]),
            .full_o (full_v[g]),
            .drop_o (drop_v[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (advance) begin
            if (bypass_i == PATH_BYPASS) begin
                s_d.rev_data = fwd_data_i;
                s_d.ovf      = 1'b0;
            end else begin
                s_d.rev_data = pop_data_v[~s_q.wr_sel];
                s_d.ovf      = |drop_v;
                if (fall) s_d.wr_sel = ~s_q.wr_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rev_data_o = s_q.rev_data;
    assign wr_sel_o   = s_q.wr_sel;
    assign ovf_o      = s_q.ovf;

    // R2
    single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_v) && $onehot0(pop_v));

    // R3
    swap_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (wr_sel_o != $past(wr_sel_o)))
            |-> $past(!hold_i && !bypass_i && !xfer_i));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && hold_i)
            |-> ($stable(rev_data_o) && $stable(wr_sel_o) && $stable(ovf_o)));

    // R5
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !hold_i && bypass_i) |-> (rev_data_o == $past(fwd_data_i)));

    // R7
    ovf_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !hold_i && !bypass_i && full_v[wr_sel_o]) |-> ovf_o);

endmodule

// File: tb/pingpong_reverser_bench.sv
module pingpong_reverser_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 10;

    typedef struct packed {
        logic         hold;
        logic         byp;
        logic         xfer;
        logic [W-1:0] din;
        logic [W-1:0] exp;
        logic         sel;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 10'd11, 10'd0,  1'b0},
        '{1'b0, 1'b0, 1'b1, 10'd12, 10'd0,  1'b0},
        '{1'b0, 1'b0, 1'b0, 10'd13, 10'd0,  1'b1},
        '{1'b0, 1'b0, 1'b0, 10'd21, 10'd13, 1'b1},
        '{1'b1, 1'b0, 1'b1, 10'd99, 10'd13, 1'b1},
        '{1'b0, 1'b0, 1'b1, 10'd22, 10'd12, 1'b1},
        '{1'b0, 1'b0, 1'b0, 10'd23, 10'd11, 1'b0},
        '{1'b0, 1'b0, 1'b0, 10'd31, 10'd23, 1'b0},
        '{1'b0, 1'b0, 1'b0, 10'd32, 10'd22, 1'b0},
        '{1'b0, 1'b1, 1'b0, 10'd77, 10'd77, 1'b0},
        '{1'b0, 1'b1, 1'b1, 10'd78, 10'd78, 1'b0},
        '{1'b0, 1'b1, 1'b0, 10'd79, 10'd79, 1'b0},
        '{1'b0, 1'b0, 1'b0, 10'd33, 10'd21, 1'b0},
        '{1'b0, 1'b0, 1'b1, 10'd34, 10'd0,  1'b0},
        '{1'b0, 1'b0, 1'b0, 10'd35, 10'd0,  1'b1},
        '{1'b0, 1'b0, 1'b1, 10'd0,  10'd35, 1'b1},
        '{1'b0, 1'b0, 1'b1, 10'd0,  10'd34, 1'b1},
        '{1'b0, 1'b0, 1'b1, 10'd0,  10'd33, 1'b1},
        '{1'b1, 1'b0, 1'b1, 10'd0,  10'd33, 1'b1},
        '{1'b0, 1'b0, 1'b1, 10'd0,  10'd32, 1'b1},
        '{1'b0, 1'b0, 1'b1, 10'd0,  10'd31, 1'b1},
        '{1'b0, 1'b0, 1'b1, 10'd0,  10'd0,  1'b1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hold_i = 1'b0;
    logic         bypass_i = 1'b0;
    logic         xfer_i = 1'b0;
    logic [W-1:0] fwd_data_i = '0;
    logic [W-1:0] rev_data_o;
    logic         wr_sel_o;
    logic         ovf_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pingpong_reverser u_pingpong_reverser (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold_i),
        .bypass_i   (bypass_i),
        .xfer_i     (xfer_i),
        .fwd_data_i (fwd_data_i),
        .rev_data_o (rev_data_o),
        .wr_sel_o   (wr_sel_o),
        .ovf_o      (ovf_o)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic step(input logic h, input logic b, input logic x, input logic [W-1:0] d);
        hold_i     = h;
        bypass_i   = b;
        xfer_i     = x;
        fwd_data_i = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        hold_i   = 1'b0;
        bypass_i = 1'b0;
        xfer_i   = 1'b0;
        fwd_data_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 rev_data after reset", int'(rev_data_o), 0);
        check("R1 wr_sel after reset", int'(wr_sel_o), 0);
        check("R1 ovf after reset", int'(ovf_o), 0);

        // table walk: R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            string tag;
            step(VECS[i].hold, VECS[i].byp, VECS[i].xfer, VECS[i].din);
            if (VECS[i].hold)     tag = "R6 hold";
            else if (VECS[i].byp) tag = "R5 bypass";
            else if (i == 12)     tag = "R9 resume after bypass";
            else if (VECS[i].exp == '0) tag = "R8 empty pop";
            else                  tag = "R4 reversed order";
            check({tag, " data"}, int'(rev_data_o), int'(VECS[i].exp));
            check("R3 role select", int'(wr_sel_o), int'(VECS[i].sel));
            check("R2 no overflow", int'(ovf_o), 0);
        end

        // R1: mid-run reset clears both stacks
        do_reset();
        check("R1 rev_data after mid-run reset", int'(rev_data_o), 0);
        check("R1 wr_sel after mid-run reset", int'(wr_sel_o), 0);
        step(1'b0, 1'b0, 1'b1, 10'd5);
        check("R1 stack 1 empty", int'(rev_data_o), 0);
        step(1'b0, 1'b0, 1'b0, 10'd6);
        check("R3 swap after reset", int'(wr_sel_o), 1);
        step(1'b0, 1'b0, 1'b1, 10'd0);
        check("R4 first drained", int'(rev_data_o), 6);
        step(1'b0, 1'b0, 1'b1, 10'd0);
        check("R4 second drained", int'(rev_data_o), 5);
        step(1'b0, 1'b0, 1'b1, 10'd0);
        check("R1 stack 0 held nothing else", int'(rev_data_o), 0);

        // R7: overflow at depth 16
        do_reset();
        for (int k = 0; k < 16; k++) step(1'b0, 1'b0, 1'b1, W'(100 + k));
        check("R7 no ovf when just full", int'(ovf_o), 0);
        step(1'b0, 1'b0, 1'b1, 10'd116);
        check("R7 ovf on dropped push", int'(ovf_o), 1);
        step(1'b0, 1'b0, 1'b0, 10'd117);
        check("R7 ovf on second dropped push", int'(ovf_o), 1);
        check("R3 swap at full", int'(wr_sel_o), 1);
        for (int j = 0; j < 16; j++) begin
            step(1'b0, 1'b0, 1'b1, W'(200 + j));
            check("R7 kept entries drain reversed", int'(rev_data_o), 115 - j);
            if (j == 0) check("R7 ovf clears", int'(ovf_o), 0);
        end
        step(1'b0, 1'b0, 1'b1, 10'd0);
        check("R8 pop past bottom", int'(rev_data_o), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule